// File: doc/BRIEF.md
# Cumulative-Benefit Accelerator Residency Controller

This block decides online which precomputed accelerator configurations stay resident in a reconfigurable region of fixed area. Each accelerator has a table entry that software writes. The entry holds the runtime of its application on the processor alone, the runtime with the accelerator, the time needed to load the accelerator, and the area it occupies. For every entry the block also keeps a running savings score.

Each application request names an accelerator. On that request every score decays by a programmable fraction. The requested score then grows by the time one accelerated run would have saved. From the updated scores the block decides whether to load the requested accelerator. It also decides which resident accelerators, if any, must give up their area. It loads only when the past savings outweigh the reconfiguration cost and the savings of whatever would be displaced.

The block issues exactly one decision per request, at a fixed latency. It keeps the resident set and the occupied area up to date. The actual reconfiguration and the runtime measurements are done elsewhere.

Top module: `cbm_manager`

## Requirements
- R1: After reset, `resident` is all zero, `area_used` is zero, `dec_valid` is low, and every table entry and score is zero.
- R2: A request takes effect in one step. First every score becomes floor(score × F / 256), where F is `fade_q` limited to at most 256, so that 256 means no decay. Then the requested score adds max(cpu_time − acc_time, 0), saturating at 2^CB_W − 1. A table write to an entry clears that entry's score.
- R3: A request is sampled on the rising edge at which `req_valid` is high. Its decision is presented for exactly one cycle, with `dec_valid` high, after the second rising edge that follows. Back-to-back requests give back-to-back decisions, in request order.
- R4: A request for an accelerator that is already resident gives `dec_load` = 0 and `dec_evict` = 0. `resident` and `area_used` stay unchanged.
- R5: A non-resident accelerator whose updated score is not strictly greater than its load time is not loaded.
- R6: An accelerator whose area exceeds REGION_AREA is never loaded.
- R7: An eligible accelerator whose area fits in REGION_AREA − `area_used` is loaded with no eviction.
- R8: Otherwise the residents are taken in ascending score order, with equal scores taken lower index first. They are taken until the free area plus the area taken covers the candidate. The candidate loads only if its score minus its load time is strictly greater than the summed scores of the residents taken. On a load, `dec_evict` bit i marks accelerator i as evicted, and the evicted bits are cleared from `resident`.
- R9: Bit i of `resident` means accelerator i is resident. `area_used` always equals the summed area of the resident accelerators and never exceeds REGION_AREA. Changing the area of a resident entry is not allowed.
- R10: With a load time of 200, a saving of 190 per run and no decay, the first request for an accelerator does not load it and the second request does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | ID_W | Entry written |
| cfg_cpu_time | input | TIME_W | Runtime without the accelerator |
| cfg_acc_time | input | TIME_W | Runtime with the accelerator |
| cfg_load_time | input | TIME_W | Reconfiguration time of the accelerator |
| cfg_area | input | AREA_W | Area the accelerator occupies |
| fade_q | input | 9 | Decay factor, value/256, clipped to 256 |
| req_valid | input | 1 | Application request strobe |
| req_id | input | ID_W | Accelerator of the requested application |
| dec_valid | output | 1 | Decision strobe, one per request |
| dec_load | output | 1 | Load the requested accelerator |
| dec_evict | output | N_ACC | Residents to evict for this load |
| resident | output | N_ACC | Current resident set |
| area_used | output | SUMA_W | Area occupied by residents |

## Verification
A score that is wrong inside the table cannot be seen directly. It shows up only when a later request crosses a load threshold, or decides a contest against residents, on the wrong request. For that reason the sweeps run long request streams with several decay values, against an arithmetic model of the scores. A wrong victim order or a wrong area count shows at the ports on the very decision concerned, in `dec_evict`, `resident` and `area_used`. A latency or pulse error shows within two cycles, on `dec_valid`.

// File: rtl/cbm_pkg.sv
// Package: constants shared by the residency controller.
// Assumes the decay factor is an unsigned fraction with FRAC_W fraction bits.
package cbm_pkg;
    localparam int FRAC_W   = 8;
    localparam int FADE_W   = FRAC_W + 1;
    localparam int FADE_ONE = 1 << FRAC_W;
endpackage

// File: rtl/cbm_fade_unit.sv
// Module: next value of one savings score. The score is decayed by the
// fraction fade_q / 2^FRAC_W (clipped to 1.0, truncated), then the saving
// is added when selected, with saturation.
// Assumes ADD_W <= CB_W.
module cbm_fade_unit #(
    parameter int CB_W  = 16,
    parameter int ADD_W = 12
) (
    input  logic [CB_W-1:0]           cb_in,
    input  logic [cbm_pkg::FADE_W-1:0] fade_q,
    input  logic                      add_en,
    input  logic [ADD_W-1:0]          add_val,
    output logic [CB_W-1:0]           cb_out
);
    import cbm_pkg::*;

    localparam int PROD_W = CB_W + FRAC_W;

    logic [FADE_W-1:0] fade_eff;
    logic [PROD_W-1:0] prod;
    logic [CB_W-1:0]   faded;
    logic [CB_W:0]     sum;

    // Decay, accumulate and saturate.
    always_comb begin
        fade_eff = (fade_q > FADE_W'(FADE_ONE)) ? FADE_W'(FADE_ONE) : fade_q;
        prod     = PROD_W'(cb_in) * PROD_W'(fade_eff);
        faded    = CB_W'(prod >> FRAC_W);
        sum      = {1'b0, faded} + (add_en ? (CB_W+1)'(add_val) : '0);
        cb_out   = sum[CB_W] ? '1 : sum[CB_W-1:0];
    end
endmodule

// File: rtl/cbm_table.sv
// Module: per-accelerator table (runtimes, load time, area) and savings
// scores. A write loads one entry and clears its score. A request updates
// every score in the same cycle.
// Assumes a write and a request to the same entry in one cycle keep the write.
module cbm_table #(
    parameter int N_ACC  = 4,
    parameter int ID_W   = 2,
    parameter int TIME_W = 12,
    parameter int CB_W   = 16,
    parameter int AREA_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [ID_W-1:0]               cfg_idx,
    input  logic [TIME_W-1:0]             cfg_cpu_time,
    input  logic [TIME_W-1:0]             cfg_acc_time,
    input  logic [TIME_W-1:0]             cfg_load_time,
    input  logic [AREA_W-1:0]             cfg_area,
    input  logic [cbm_pkg::FADE_W-1:0]    fade_q,
    input  logic                          upd_en,
    input  logic [ID_W-1:0]               upd_id,
    output logic [N_ACC-1:0][CB_W-1:0]    cb_vec,
    output logic [N_ACC-1:0][TIME_W-1:0]  load_vec,
    output logic [N_ACC-1:0][AREA_W-1:0]  area_vec
);
    for (genvar g = 0; g < N_ACC; g++) begin : g_entry
        logic [TIME_W-1:0] cpu_q;
        logic [TIME_W-1:0] acc_q;
        logic [TIME_W-1:0] load_q;
        logic [AREA_W-1:0] area_q;
        logic [CB_W-1:0]   cb_q;
        logic [CB_W-1:0]   cb_nxt;
        logic [TIME_W-1:0] saving;
        logic              sel_wr;
        logic              sel_add;

        // Saving per run, never negative.
        always_comb begin
            saving  = (cpu_q > acc_q) ? (cpu_q - acc_q) : '0;
            sel_wr  = cfg_we && (cfg_idx == ID_W'(g));
            sel_add = (upd_id == ID_W'(g));
        end

        cbm_fade_unit #(.CB_W(CB_W), .ADD_W(TIME_W)) u_fade (
            .cb_in   (cb_q),
            .fade_q  (fade_q),
            .add_en  (sel_add),
            .add_val (saving),
            .cb_out  (cb_nxt)
        );

        // Entry storage: write, or score update on a request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cpu_q  <= '0;
                acc_q  <= '0;
                load_q <= '0;
                area_q <= '0;
                cb_q   <= '0;
            end else if (sel_wr) begin
                cpu_q  <= cfg_cpu_time;
                acc_q  <= cfg_acc_time;
                load_q <= cfg_load_time;
                area_q <= cfg_area;
                cb_q   <= '0;
            end else if (upd_en) begin
                cb_q   <= cb_nxt;
            end
        end

        assign cb_vec[g]   = cb_q;
        assign load_vec[g] = load_q;
        assign area_vec[g] = area_q;
    end
endmodule

// File: rtl/cbm_victim_select.sv
// Module: greedy victim choice. Residents are ranked by ascending score,
// with ties broken by lower index. A resident is taken while the free area
// plus the area of the lower-ranked residents is below the need. Returns
// the victims, their area and their summed score.
// Assumes all widths are wide enough for the sums (set by the top).
module cbm_victim_select #(
    parameter int N_ACC  = 4,
    parameter int CB_W   = 16,
    parameter int AREA_W = 6,
    parameter int SUMA_W = 9,
    parameter int SUMB_W = 19
) (
    input  logic [N_ACC-1:0]              res_mask,
    input  logic [N_ACC-1:0][CB_W-1:0]    cb_vec,
    input  logic [N_ACC-1:0][AREA_W-1:0]  area_vec,
    input  logic [SUMA_W-1:0]             free_area,
    input  logic [SUMA_W-1:0]             need_area,
    output logic [N_ACC-1:0]              victims,
    output logic [SUMA_W-1:0]             freed_area,
    output logic [SUMB_W-1:0]             victim_cb_sum
);
    for (genvar j = 0; j < N_ACC; j++) begin : g_rank
        logic [SUMA_W-1:0] prior;
        logic              take;

        // Area available before resident j would be reached in the order.
        always_comb begin
            prior = free_area;
            for (int k = 0; k < N_ACC; k++) begin
                if (res_mask[k] &&
                    ((cb_vec[k] < cb_vec[j]) || ((cb_vec[k] == cb_vec[j]) && (k < j))))
                    prior = prior + SUMA_W'(area_vec[k]);
            end
            take = res_mask[j] && (prior < need_area);
        end

        assign victims[j] = take;
    end

    // Totals over the chosen victims.
    always_comb begin
        freed_area    = '0;
        victim_cb_sum = '0;
        for (int k = 0; k < N_ACC; k++) begin
            if (victims[k]) begin
                freed_area    = freed_area + SUMA_W'(area_vec[k]);
                victim_cb_sum = victim_cb_sum + SUMB_W'(cb_vec[k]);
            end
        end
    end
endmodule

// File: rtl/cbm_manager.sv
// Module: top of the residency controller. A request updates the scores
// on the edge that samples it. The decision and the new resident set are
// registered on the next edge from the updated scores, so one decision
// follows each request at a fixed latency.
// Assumes the area of a resident entry is not rewritten.
module cbm_manager #(
    parameter int N_ACC       = 4,
    parameter int TIME_W      = 12,
    parameter int CB_W        = 16,
    parameter int AREA_W      = 6,
    parameter int REGION_AREA = 40,
    localparam int ID_W       = (N_ACC > 1) ? $clog2(N_ACC) : 1,
    localparam int SUMA_W     = $clog2(REGION_AREA + N_ACC * (2 ** AREA_W)) + 1,
    localparam int SUMB_W     = CB_W + $clog2(N_ACC) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ID_W-1:0]            cfg_idx,
    input  logic [TIME_W-1:0]          cfg_cpu_time,
    input  logic [TIME_W-1:0]          cfg_acc_time,
    input  logic [TIME_W-1:0]          cfg_load_time,
    input  logic [AREA_W-1:0]          cfg_area,
    input  logic [cbm_pkg::FADE_W-1:0] fade_q,
    input  logic                       req_valid,
    input  logic [ID_W-1:0]            req_id,
    output logic                       dec_valid,
    output logic                       dec_load,
    output logic [N_ACC-1:0]           dec_evict,
    output logic [N_ACC-1:0]           resident,
    output logic [SUMA_W-1:0]          area_used
);
    logic [N_ACC-1:0][CB_W-1:0]   cb_vec;
    logic [N_ACC-1:0][TIME_W-1:0] load_vec;
    logic [N_ACC-1:0][AREA_W-1:0] area_vec;

    logic              pend_valid;
    logic [ID_W-1:0]   pend_id;
    logic [CB_W-1:0]   cand_cb;
    logic [CB_W-1:0]   cand_load;
    logic [CB_W-1:0]   gain;
    logic [SUMA_W-1:0] need_area;
    logic [SUMA_W-1:0] free_area;
    logic [SUMA_W-1:0] freed_area;
    logic [SUMB_W-1:0] victim_cb_sum;
    logic [N_ACC-1:0]  victims;
    logic [N_ACC-1:0]  cand_bit;
    logic              is_res;
    logic              over_cost;
    logic              fits_region;
    logic              fits_free;
    logic              eligible;
    logic              grant;

    cbm_table #(
        .N_ACC(N_ACC), .ID_W(ID_W), .TIME_W(TIME_W), .CB_W(CB_W), .AREA_W(AREA_W)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_idx       (cfg_idx),
        .cfg_cpu_time  (cfg_cpu_time),
        .cfg_acc_time  (cfg_acc_time),
        .cfg_load_time (cfg_load_time),
        .cfg_area      (cfg_area),
        .fade_q        (fade_q),
        .upd_en        (req_valid),
        .upd_id        (req_id),
        .cb_vec        (cb_vec),
        .load_vec      (load_vec),
        .area_vec      (area_vec)
    );

    // Candidate view and the load verdict for the pending request.
    always_comb begin
        cand_cb     = cb_vec[pend_id];
        cand_load   = CB_W'(load_vec[pend_id]);
        need_area   = SUMA_W'(area_vec[pend_id]);
        free_area   = SUMA_W'(REGION_AREA) - area_used;
        cand_bit    = N_ACC'(1) << pend_id;
        is_res      = |(resident & cand_bit);
        over_cost   = cand_cb > cand_load;
        fits_region = need_area <= SUMA_W'(REGION_AREA);
        fits_free   = need_area <= free_area;
        gain        = cand_cb - cand_load;
        eligible    = !is_res && over_cost && fits_region;
        grant       = eligible && (fits_free || (SUMB_W'(gain) > victim_cb_sum));
    end

    cbm_victim_select #(
        .N_ACC(N_ACC), .CB_W(CB_W), .AREA_W(AREA_W), .SUMA_W(SUMA_W), .SUMB_W(SUMB_W)
    ) u_victim (
        .res_mask      (resident),
        .cb_vec        (cb_vec),
        .area_vec      (area_vec),
        .free_area     (free_area),
        .need_area     (need_area),
        .victims       (victims),
        .freed_area    (freed_area),
        .victim_cb_sum (victim_cb_sum)
    );

    // Request pipeline stage: remember which request awaits a decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_id    <= '0;
        end else begin
            pend_valid <= req_valid;
            pend_id    <= req_id;
        end
    end

    // Decision register and resident bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_load  <= 1'b0;
            dec_evict <= '0;
            resident  <= '0;
            area_used <= '0;
        end else begin
            dec_valid <= pend_valid;
            dec_load  <= pend_valid && grant;
            dec_evict <= (pend_valid && grant) ? victims : '0;
            if (pend_valid && grant) begin
                resident  <= (resident & ~victims) | cand_bit;
                area_used <= area_used - freed_area + need_area;
            end
        end
    end

    AST_AREA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        area_used <= SUMA_W'(REGION_AREA)); // R9

    AST_DECISION_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(req_valid, 2)); // R3

    AST_RESIDENT_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && is_res) |=> (!dec_load && $stable(resident) && $stable(area_used))); // R4

    AST_LOAD_ABOVE_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && !over_cost) |=> !dec_load); // R5

    AST_EVICT_WAS_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> ((dec_evict & ~$past(resident)) == '0)); // R8

    AST_VICTIMS_COVER_NEED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && eligible && !fits_free) |-> (free_area + freed_area >= need_area)); // R8

    AST_FIT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && eligible && fits_free) |=> (dec_load && dec_evict == '0)); // R7
endmodule

// File: tb/cbm_manager_tb.sv
module cbm_manager_tb;
    localparam int N    = 4;
    localparam int REG  = 40;
    localparam int CBMX = 65535;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_idx = '0;
    logic [11:0] cfg_cpu_time = '0, cfg_acc_time = '0, cfg_load_time = '0;
    logic [5:0] cfg_area = '0;
    logic [8:0] fade_q = 9'd256;
    logic       req_valid = 1'b0;
    logic [1:0] req_id = '0;
    logic       dec_valid, dec_load;
    logic [3:0] dec_evict, resident;
    logic [8:0] area_used;

    cbm_manager #(.N_ACC(N), .TIME_W(12), .CB_W(16), .AREA_W(6), .REGION_AREA(REG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_cpu_time(cfg_cpu_time), .cfg_acc_time(cfg_acc_time),
        .cfg_load_time(cfg_load_time), .cfg_area(cfg_area), .fade_q(fade_q),
        .req_valid(req_valid), .req_id(req_id), .dec_valid(dec_valid),
        .dec_load(dec_load), .dec_evict(dec_evict), .resident(resident),
        .area_used(area_used)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_err = 0;
    int cycles = 0;

    // Model state, built from the requirements.
    int m_cpu[N], m_acc[N], m_load[N], m_area[N], m_cb[N];
    bit m_res[N];
    int m_used;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'(lfsr);
    endfunction

    function automatic int fade_eff();
        return (int'(fade_q) > 256) ? 256 : int'(fade_q);
    endfunction

    // Model one request; returns the expected packed ports after its decision.
    function automatic logic [17:0] m_req(input int id);
        int ben, freev, freed, sum, best;
        bit taken[N];
        bit ld;
        logic [3:0] ev;
        logic [3:0] rv;
        for (int k = 0; k < N; k++) m_cb[k] = (m_cb[k] * fade_eff()) >>> 8;
        ben = (m_cpu[id] > m_acc[id]) ? m_cpu[id] - m_acc[id] : 0;
        m_cb[id] = (m_cb[id] + ben > CBMX) ? CBMX : m_cb[id] + ben;
        ld = 1'b0; ev = '0;
        if (!m_res[id] && m_cb[id] > m_load[id] && m_area[id] <= REG) begin
            freev = REG - m_used;
            if (freev >= m_area[id]) ld = 1'b1;
            else begin
                freed = 0; sum = 0;
                for (int k = 0; k < N; k++) taken[k] = 1'b0;
                while (freev + freed < m_area[id]) begin
                    best = -1;
                    for (int k = 0; k < N; k++)
                        if (m_res[k] && !taken[k] && (best < 0 || m_cb[k] < m_cb[best])) best = k;
                    taken[best] = 1'b1; ev[best] = 1'b1;
                    freed += m_area[best]; sum += m_cb[best];
                end
                if (m_cb[id] - m_load[id] > sum) ld = 1'b1;
            end
        end
        if (!ld) ev = '0;
        if (ld) begin
            for (int k = 0; k < N; k++) if (ev[k]) begin m_res[k] = 1'b0; m_used -= m_area[k]; end
            m_res[id] = 1'b1; m_used += m_area[id];
        end
        for (int k = 0; k < N; k++) rv[k] = m_res[k];
        return {ld, ev, rv, 9'(m_used)};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < N; k++) begin
            m_cpu[k] = 0; m_acc[k] = 0; m_load[k] = 0; m_area[k] = 0; m_cb[k] = 0; m_res[k] = 0;
        end
        m_used = 0;
        chk(resident == 4'd0, "R1", "resident", resident, 0);
        chk(area_used == 9'd0, "R1", "area_used", area_used, 0);
        chk(dec_valid == 1'b0, "R1", "dec_valid", dec_valid, 0);
    endtask

    task automatic cfg(input int idx, input int cpu, input int acc, input int ld, input int ar);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_cpu_time = 12'(cpu);
        cfg_acc_time = 12'(acc); cfg_load_time = 12'(ld); cfg_area = 6'(ar);
        @(negedge clk); cfg_we = 1'b0;
        m_cpu[idx] = cpu; m_acc[idx] = acc; m_load[idx] = ld; m_area[idx] = ar; m_cb[idx] = 0;
    endtask

    task automatic do_req(input int id, input string rq, output logic [17:0] got);
        logic [17:0] exp;
        exp = m_req(id);
        @(negedge clk); req_valid = 1'b1; req_id = 2'(id);
        @(negedge clk); req_valid = 1'b0;
        chk(dec_valid == 1'b0, "R3", "early dec_valid", dec_valid, 0);
        @(negedge clk);
        chk(dec_valid == 1'b1, "R3", "dec_valid", dec_valid, 1);
        got = {dec_load, dec_evict, resident, area_used};
        chk(got == exp, rq, "load,evict,resident,area", got, exp);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R3", "single pulse", dec_valid, 0);
    endtask

    task automatic do_pair(input int a, input int b, input string rq);
        logic [17:0] e1, e2, g;
        e1 = m_req(a);
        e2 = m_req(b);
        @(negedge clk); req_valid = 1'b1; req_id = 2'(a);
        @(negedge clk); req_id = 2'(b);
        @(negedge clk); req_valid = 1'b0;
        g = {dec_load, dec_evict, resident, area_used};
        chk(dec_valid == 1'b1 && g == e1, rq, "first of pair", g, e1);
        @(negedge clk);
        g = {dec_load, dec_evict, resident, area_used};
        chk(dec_valid == 1'b1 && g == e2, rq, "second of pair", g, e2);
    endtask

    initial begin
        logic [17:0] g;
        int fades[5];
        fades = '{256, 240, 200, 128, 300};

        // R1 reset state, R10 worked example, R4 already resident.
        fade_q = 9'd256;
        do_reset();
        cfg(0, 200, 10, 200, 10);
        do_req(0, "R10", g);
        chk(g[17] == 1'b0, "R10", "first request load", g[17], 0);
        do_req(0, "R10", g);
        chk(g == {1'b1, 4'b0000, 4'b0001, 9'd10}, "R10", "second request", g, {1'b1, 4'b0000, 4'b0001, 9'd10});
        do_req(0, "R4", g);
        chk(g == {1'b0, 4'b0000, 4'b0001, 9'd10}, "R4", "resident request", g, {1'b0, 4'b0000, 4'b0001, 9'd10});

        // R2 and R5: with no memory (fade 0) a saving below cost never loads.
        fade_q = 9'd0;
        do_reset();
        cfg(1, 160, 10, 160, 5);
        for (int i = 0; i < 4; i++) begin
            do_req(1, "R5", g);
            chk(g[17] == 1'b0, "R2", "fade 0 no load", g[17], 0);
        end
        // R2 truncated decay at 128/256: scores 100, 150, 175 against cost 150.
        fade_q = 9'd128;
        do_reset();
        cfg(2, 120, 20, 150, 5);
        do_req(2, "R5", g); chk(g[17] == 1'b0, "R5", "score 100", g[17], 0);
        do_req(2, "R5", g); chk(g[17] == 1'b0, "R5", "score 150 equal", g[17], 0);
        do_req(2, "R2", g); chk(g[17] == 1'b1, "R2", "score 175", g[17], 1);

        // R6 oversized area, R7 fit, R8 eviction and refusal.
        fade_q = 9'd256;
        do_reset();
        cfg(3, 4000, 0, 10, 45);
        do_req(3, "R6", g); do_req(3, "R6", g);
        chk(g[17] == 1'b0 && resident == 4'd0, "R6", "oversized", g, 0);
        cfg(0, 100, 0, 50, 20);
        cfg(1, 60, 0, 50, 20);
        do_req(0, "R7", g);
        chk(g == {1'b1, 4'b0000, 4'b0001, 9'd20}, "R7", "fit 0", g, {1'b1, 4'b0000, 4'b0001, 9'd20});
        do_req(1, "R7", g);
        chk(g == {1'b1, 4'b0000, 4'b0011, 9'd40}, "R7", "fit 1", g, {1'b1, 4'b0000, 4'b0011, 9'd40});
        cfg(2, 200, 0, 100, 15);
        do_req(2, "R8", g);
        chk(g == {1'b1, 4'b0010, 4'b0101, 9'd35}, "R8", "evict lowest", g, {1'b1, 4'b0010, 4'b0101, 9'd35});
        cfg(3, 150, 0, 100, 25);
        do_req(3, "R8", g);
        chk(g == {1'b0, 4'b0000, 4'b0101, 9'd35}, "R8", "gain too small", g, {1'b0, 4'b0000, 4'b0101, 9'd35});

        // R8 tie: equal scores evict the lower index first.
        do_reset();
        cfg(0, 50, 0, 10, 20);
        cfg(1, 50, 0, 10, 20);
        cfg(2, 300, 0, 100, 10);
        do_req(0, "R8", g); do_req(1, "R8", g); do_req(2, "R8", g);
        chk(g == {1'b1, 4'b0001, 4'b0110, 9'd30}, "R8", "tie order", g, {1'b1, 4'b0001, 4'b0110, 9'd30});

        // Sweeps: several decay values, long request streams, some back to back.
        for (int p = 0; p < 5; p++) begin
            fade_q = 9'(fades[p]);
            do_reset();
            for (int k = 0; k < N; k++)
                cfg(k, rnd() % 600 + 50, rnd() % 100, rnd() % 500,
                    (p == 4 && k == 3) ? 45 : rnd() % 25 + 1);
            for (int i = 0; i < 60; i++) begin
                if (i % 7 == 3) do_pair(rnd() % N, rnd() % N, "R3 R8");
                else do_req(rnd() % N, "R2 R8 R9", g);
                chk(area_used <= 9'(REG), "R9", "area bound", area_used, REG);
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule